// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is the control logic behind one general-purpose I/O port of `WIDTH` pins (8 by default). Software writes a data-out latch, a single port-wide drive mode and a per-pin interrupt mask over a simple register bus. From the latched data and the mode, the block computes three driver controls for every pin: a pull-up enable, a low-side sink enable and a high-side drive enable. These controls steer the pad transistors, which lie outside the block.

Pin levels come back through a two-flop synchronizer. A port read returns the synchronized levels, not the latch. When an enabled pin's synchronized level falls from 1 to 0, that pin raises a request. The single interrupt output is the OR of all requests. Open-drain pins with a 1 latched are neither driven nor pulled up, so they can serve as high-impedance inputs.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the mode is resistive and every data-out bit is 1. So `pullup_en_o` is all ones, `sink_en_o` and `drive_en_o` are all zeros, `irq_o` is 0 and `rd_data_o` is all ones.
- R2: A pin's pull-up enable is 1 only when the mode is resistive (code 00) and its data-out bit is 1. Otherwise it is 0.
- R3: A pin's sink enable equals the inverse of its data-out bit in every mode.
- R4: A pin's high-side drive enable is 1 only when the mode is CMOS (code 01) and its data-out bit is 1.
- R5: In open-drain mode (code 10), and in the reserved code 11 that behaves the same, a pin with data-out 1 has all three enables at 0.
- R6: A write with `data_we_i`, `cfg_we_i` or `irq_en_we_i` takes effect at the next rising clock edge. The mode is taken from `wr_data_i[1:0]`, and the data latch and the interrupt mask take all of `wr_data_i`.
- R7: `rd_data_o` shows a change of `pin_i` after two rising edges. It never reflects the data-out latch.
- R8: A 1-to-0 change on a pin whose mask bit is 1 raises `irq_o` for exactly one cycle. `irq_o` rises in the same cycle as the new level appears on `rd_data_o`.
- R9: A falling edge on a masked-off pin, or a rising edge on any pin, leaves `irq_o` at 0.
- R10: No pin ever has its sink enabled together with its pull-up or its high-side drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | WIDTH | Write data shared by all three write strobes |
| data_we_i | input | 1 | Load the data-out latch |
| cfg_we_i | input | 1 | Load the mode from wr_data_i[1:0] |
| irq_en_we_i | input | 1 | Load the per-pin interrupt mask |
| pin_i | input | WIDTH | Asynchronous pin levels |
| rd_data_o | output | WIDTH | Synchronized pin levels |
| pullup_en_o | output | WIDTH | Per-pin pull-up enable |
| sink_en_o | output | WIDTH | Per-pin low-side sink enable |
| drive_en_o | output | WIDTH | Per-pin high-side drive enable |
| irq_o | output | 1 | Port interrupt request |

## Verification
The driver enables are decoded straight from registers, so they are due one rising edge after a write strobe. The bench holds each strobe for one cycle and samples on the following falling edge. A pin change passes two synchronizer flops, so `rd_data_o` and `irq_o` are both due after the second rising edge. The bench checks that the request is still low after only one edge, is high after two, and is low again after three, which confirms the one-cycle width. Every sample is taken on a falling clock edge, half a period away from the edge that updates the registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_RES  = 2'b00,
    MODE_CMOS = 2'b01,
    MODE_OD   = 2'b10
  } gpio_mode_e;

  // reserved code 11 folds onto open drain
  function automatic gpio_mode_e decode_mode(logic [1:0] code);
    case (code)
      2'b00:   return MODE_RES;
      2'b01:   return MODE_CMOS;
      default: return MODE_OD;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_pkg::*;
(
  input  gpio_mode_e mode_i,
  input  logic       data_i,
  output logic       pullup_o,
  output logic       sink_o,
  output logic       drive_o
);
  always_comb begin
    sink_o   = ~data_i;
    pullup_o = data_i && (mode_i == MODE_RES);
    drive_o  = data_i && (mode_i == MODE_CMOS);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= level_i;
  end

  assign fall  = prev_q & ~level_i & mask_i;
  assign irq_o = |fall;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             data_we_i,
  input  logic             cfg_we_i,
  input  logic             irq_en_we_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] pullup_en_o,
  output logic [WIDTH-1:0] sink_en_o,
  output logic [WIDTH-1:0] drive_en_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] data_q, mask_q, sync_lvl;
  gpio_mode_e       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '1;
      mask_q <= '0;
      mode_q <= MODE_RES;
    end else begin
      if (data_we_i)   data_q <= wr_data_i;
      if (irq_en_we_i) mask_q <= wr_data_i;
      if (cfg_we_i)    mode_q <= decode_mode(wr_data_i[1:0]);
    end
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_lvl)
  );

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    gpio_pin_drv u_drv (
      .mode_i  (mode_q),
      .data_i  (data_q[g]),
      .pullup_o(pullup_en_o[g]),
      .sink_o  (sink_en_o[g]),
      .drive_o (drive_en_o[g])
    );
  end

  gpio_edge_irq #(.WIDTH(WIDTH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(sync_lvl),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  assign rd_data_o = sync_lvl;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             data_we_i,
  input logic             cfg_we_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic [WIDTH-1:0] pullup_en_o,
  input logic [WIDTH-1:0] sink_en_o,
  input logic [WIDTH-1:0] drive_en_o,
  input logic             irq_o
);
  // R3
  sink_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> sink_en_o == ~$past(wr_data_i));

  // R4
  no_drive_outside_cmos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_data_i[1:0] != 2'b01) |=> drive_en_o == '0);

  // R5
  od_no_pullup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_data_i[1]) |=> pullup_en_o == '0);

  // R8
  irq_needs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (($past(rd_data_o) & ~rd_data_o) != '0));

  // R10
  sink_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_en_o & (pullup_en_o | drive_en_o)) == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_data_i  (wr_data_i),
  .data_we_i  (data_we_i),
  .cfg_we_i   (cfg_we_i),
  .rd_data_o  (rd_data_o),
  .pullup_en_o(pullup_en_o),
  .sink_en_o  (sink_en_o),
  .drive_en_o (drive_en_o),
  .irq_o      (irq_o)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] wr_data = 0;
  logic       data_we = 0, cfg_we = 0, irq_en_we = 0;
  logic [7:0] pin = 8'hFF;
  logic [7:0] rd_data, pullup_en, sink_en, drive_en;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data),
    .data_we_i(data_we), .cfg_we_i(cfg_we), .irq_en_we_i(irq_en_we),
    .pin_i(pin), .rd_data_o(rd_data), .pullup_en_o(pullup_en),
    .sink_en_o(sink_en), .drive_en_o(drive_en), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int which, logic [7:0] v);
    @(negedge clk);
    wr_data = v;
    data_we = (which == 0); cfg_we = (which == 1); irq_en_we = (which == 2);
    @(negedge clk);
    data_we = 0; cfg_we = 0; irq_en_we = 0;
  endtask

  task automatic drv_check(string req, logic [7:0] pu, logic [7:0] sk, logic [7:0] dr);
    chk({req, " pullup"}, pullup_en, pu);
    chk({req, " sink"}, sink_en, sk);
    chk({req, " drive"}, drive_en, dr);
  endtask

  task automatic t_reset;
    drv_check("R1", 8'hFF, 8'h00, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 read", rd_data, 8'hFF);
  endtask

  task automatic t_resistive;
    wr(0, 8'hA5); // R6 data write applies after one edge
    drv_check("R2 R3 resistive", 8'hA5, 8'h5A, 8'h00);
  endtask

  task automatic t_cmos;
    wr(1, 8'hFD); // R6 only bits 1:0 matter -> code 01
    drv_check("R4 R3 cmos", 8'h00, 8'h5A, 8'hA5);
    wr(0, 8'h3C);
    drv_check("R4 cmos data", 8'h00, 8'hC3, 8'h3C);
  endtask

  task automatic t_open_drain;
    wr(1, 8'h02);
    drv_check("R5 od", 8'h00, 8'hC3, 8'h00);
    wr(1, 8'h03);
    drv_check("R5 reserved", 8'h00, 8'hC3, 8'h00);
    wr(1, 8'h00);
    drv_check("R2 back to resistive", 8'h3C, 8'hC3, 8'h00);
  endtask

  task automatic t_read;
    wr(0, 8'h00);
    @(negedge clk); pin = 8'h96;
    @(negedge clk);
    chk("R7 one edge", rd_data, 8'hFF);
    @(negedge clk);
    chk("R7 two edges", rd_data, 8'h96);
    @(negedge clk); pin = 8'hFF;
    @(negedge clk); @(negedge clk);
    chk("R7 not latch", rd_data, 8'hFF);
  endtask

  task automatic t_irq;
    wr(2, 8'h08);
    @(negedge clk); pin = 8'hF7;
    @(negedge clk);
    chk("R8 early", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 raised", {7'd0, irq}, 8'h01);
    chk("R8 read aligned", rd_data, 8'hF7);
    @(negedge clk);
    chk("R8 one cycle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_irq_masked;
    @(negedge clk); pin = 8'hF3;
    @(negedge clk); @(negedge clk);
    chk("R9 masked fall", {7'd0, irq}, 8'h00);
    @(negedge clk); pin = 8'hFB;
    @(negedge clk); @(negedge clk);
    chk("R9 rise", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 rise later", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_resistive();
    t_cmos();
    t_open_drain();
    t_read();
    t_irq();
    t_irq_masked();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=hang exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule